// File: doc/BRIEF.md
# Dual-Converter Lockstep Conversion Sequencer

This block drives two analog-to-digital converters (side A and side B) so that every conversion on one side is paired with a conversion on the other side in the same cycle. Each side has its own list of channel numbers and sample times for two groups. The regular group is a long scan that produces DMA words. The inserted group is a short scan whose results are kept in per-rank result registers. A selectable edge on one of several trigger lines starts a group. The start pulse goes to both converters together. The converters are modelled as start/done/data handshakes.

When both converters have delivered their sample for a regular rank, the pair is packed into one word and a one-cycle DMA request is raised. Sticky end-of-group flags are raised once both sides have finished the whole group. The interrupt outputs are gated by enable bits from either side. A paired-rank configuration checker watches for setups that cannot be sampled safely, and while such a setup is present, triggers are refused.

Top module: `dual_conv_seq`

## Requirements
- R1: A synchronous reset clears the rank counters, the pending inserted request, all sticky flags, the DMA request and the start pulses. A scan that starts after reset begins at rank 0.
- R2: The regular group starts on a rising edge of `reg_trig_src[reg_sel]`. The inserted group starts on a rising edge of `ins_trig_src[ins_sel]`. Edges on lines that are not selected have no effect.
- R3: `conv_start_a` and `conv_start_b` pulse high for exactly one cycle, in the same cycle. With them, `conv_ch_x` and `conv_st_x` present each side's own entry for the current rank. Rank r's channel is held in bits [r*5 +: 5] of the channel list, and its sample time in bits [r*3 +: 3] of the sample-time list.
- R4: A regular rank completes only when both sides have returned done, in either order. At that point `dma_word` = {side B sample, side A sample} (B in bits 31:16) and `dma_req` is high for one cycle. The next rank starts one cycle later.
- R5: The regular group converts ranks 0..`reg_len` (up to 16). `eoc_flag` rises together with the DMA request of the last rank and not earlier. `eoc_irq` = `eoc_flag` AND (`eoc_ie_a` OR `eoc_ie_b`).
- R6: The inserted group converts ranks 0..`ins_len` (up to 4). Rank r stores side A's result in `ins_data_a[r*16 +: 16]` and side B's result in `ins_data_b[r*16 +: 16]`, and raises no DMA request. `eoic_flag` rises after the last rank. `eoic_irq` = `eoic_flag` AND (`eoic_ie_a` OR `eoic_ie_b`).
- R7: An inserted trigger that arrives during a regular scan lets the current regular rank finish. The whole inserted group then runs, and the regular scan resumes at the next rank.
- R8: A regular trigger while either group is active or an inserted group is pending is ignored, and so is an inserted trigger while the inserted group is active or pending. Either case sets the sticky `ovr_flag`.
- R9: `eoc_flag`, `eoic_flag` and `ovr_flag` stay set until a one-cycle pulse on `clr_eoc`, `clr_eoic` or `clr_ovr`.
- R10: `cfg_err` goes high one cycle after some enabled rank (rank ≤ the group's length) has equal channel numbers on both sides, or has different sample times on the two sides. Ranks above the length are not checked. While `cfg_err` is high, triggers are ignored and do not set `ovr_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_trig_src | input | 8 | Regular trigger source lines |
| ins_trig_src | input | 8 | Inserted trigger source lines |
| reg_sel | input | 3 | Regular trigger line select |
| ins_sel | input | 3 | Inserted trigger line select |
| reg_len | input | 4 | Last regular rank index |
| ins_len | input | 2 | Last inserted rank index |
| reg_ch_a | input | 80 | Side A regular channel list, 5 bits per rank |
| reg_ch_b | input | 80 | Side B regular channel list |
| reg_st_a | input | 48 | Side A regular sample times, 3 bits per rank |
| reg_st_b | input | 48 | Side B regular sample times |
| ins_ch_a | input | 20 | Side A inserted channel list |
| ins_ch_b | input | 20 | Side B inserted channel list |
| ins_st_a | input | 12 | Side A inserted sample times |
| ins_st_b | input | 12 | Side B inserted sample times |
| eoc_ie_a | input | 1 | Side A regular-end interrupt enable |
| eoc_ie_b | input | 1 | Side B regular-end interrupt enable |
| eoic_ie_a | input | 1 | Side A inserted-end interrupt enable |
| eoic_ie_b | input | 1 | Side B inserted-end interrupt enable |
| clr_eoc | input | 1 | Clear pulse for eoc_flag |
| clr_eoic | input | 1 | Clear pulse for eoic_flag |
| clr_ovr | input | 1 | Clear pulse for ovr_flag |
| conv_start_a | output | 1 | Start pulse to side A |
| conv_start_b | output | 1 | Start pulse to side B |
| conv_ch_a | output | 5 | Side A channel for current rank |
| conv_ch_b | output | 5 | Side B channel for current rank |
| conv_st_a | output | 3 | Side A sample time for current rank |
| conv_st_b | output | 3 | Side B sample time for current rank |
| conv_done_a | input | 1 | Side A conversion done |
| conv_done_b | input | 1 | Side B conversion done |
| conv_data_a | input | 16 | Side A sample, valid with done |
| conv_data_b | input | 16 | Side B sample, valid with done |
| dma_req | output | 1 | One-cycle DMA request |
| dma_word | output | 32 | Packed pair {B, A} |
| ins_data_a | output | 64 | Side A inserted results, 16 bits per rank |
| ins_data_b | output | 64 | Side B inserted results |
| eoc_flag | output | 1 | Regular group finished (sticky) |
| eoic_flag | output | 1 | Inserted group finished (sticky) |
| ovr_flag | output | 1 | Trigger overrun (sticky) |
| eoc_irq | output | 1 | Gated regular-end interrupt |
| eoic_irq | output | 1 | Gated inserted-end interrupt |
| cfg_err | output | 1 | Paired-rank configuration error |

## Verification
The bench builds the block with its default parameters: 16-bit samples, 16 regular ranks, 4 inserted ranks, 5-bit channels, 3-bit sample times and eight trigger lines behind a 3-bit select. These defaults make the full 16-rank scan reachable, with the two sides on lists offset by fourteen channels. They also make the last-rank limit of the inserted result registers reachable. The converter models on the two sides use unequal latencies, and the bench swaps which side is slower. This exercises the pairing wait in both directions, and it lets an inserted trigger land while a regular rank is still in flight.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
    typedef enum logic [0:0] {
        GRP_REG = 1'b0,
        GRP_INS = 1'b1
    } dcs_grp_e;
endpackage

// File: rtl/dcs_trig_mux.sv
module dcs_trig_mux #(
    parameter int NSRC = 8,
    parameter int SELW = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src,
    input  logic [SELW-1:0] sel,
    output logic            fire
);
    logic [NSRC-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = src;
        fire   = src[sel] & ~prev_q[sel];
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '1;
        else     prev_q <= prev_d;
    end
endmodule

// File: rtl/dcs_cfg_check.sv
module dcs_cfg_check #(
    parameter int RANKS = 16,
    parameter int CHW   = 5,
    parameter int STW   = 3,
    parameter int LW    = 4
) (
    input  logic [RANKS*CHW-1:0] ch_a,
    input  logic [RANKS*CHW-1:0] ch_b,
    input  logic [RANKS*STW-1:0] st_a,
    input  logic [RANKS*STW-1:0] st_b,
    input  logic [LW-1:0]        len,
    output logic                 bad
);
    logic [RANKS-1:0] bad_r;

    for (genvar r = 0; r < RANKS; r++) begin : g_rank
        always_comb begin
            bad_r[r] = (r <= int'(len)) &&
                       ((ch_a[r*CHW +: CHW] == ch_b[r*CHW +: CHW]) ||
                        (st_a[r*STW +: STW] != st_b[r*STW +: STW]));
        end
    end

    assign bad = |bad_r;
endmodule

// File: rtl/dual_conv_seq.sv
module dual_conv_seq
    import dcs_pkg::*;
#(
    parameter int SMPW      = 16,
    parameter int REG_RANKS = 16,
    parameter int INS_RANKS = 4,
    parameter int CHW       = 5,
    parameter int STW       = 3,
    parameter int NSRC      = 8,
    parameter int SELW      = 3,
    localparam int RLW      = $clog2(REG_RANKS),
    localparam int ILW      = $clog2(INS_RANKS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NSRC-1:0]          reg_trig_src,
    input  logic [NSRC-1:0]          ins_trig_src,
    input  logic [SELW-1:0]          reg_sel,
    input  logic [SELW-1:0]          ins_sel,
    input  logic [RLW-1:0]           reg_len,
    input  logic [ILW-1:0]           ins_len,
    input  logic [REG_RANKS*CHW-1:0] reg_ch_a,
    input  logic [REG_RANKS*CHW-1:0] reg_ch_b,
    input  logic [REG_RANKS*STW-1:0] reg_st_a,
    input  logic [REG_RANKS*STW-1:0] reg_st_b,
    input  logic [INS_RANKS*CHW-1:0] ins_ch_a,
    input  logic [INS_RANKS*CHW-1:0] ins_ch_b,
    input  logic [INS_RANKS*STW-1:0] ins_st_a,
    input  logic [INS_RANKS*STW-1:0] ins_st_b,
    input  logic                     eoc_ie_a,
    input  logic                     eoc_ie_b,
    input  logic                     eoic_ie_a,
    input  logic                     eoic_ie_b,
    input  logic                     clr_eoc,
    input  logic                     clr_eoic,
    input  logic                     clr_ovr,
    output logic                     conv_start_a,
    output logic                     conv_start_b,
    output logic [CHW-1:0]           conv_ch_a,
    output logic [CHW-1:0]           conv_ch_b,
    output logic [STW-1:0]           conv_st_a,
    output logic [STW-1:0]           conv_st_b,
    input  logic                     conv_done_a,
    input  logic                     conv_done_b,
    input  logic [SMPW-1:0]          conv_data_a,
    input  logic [SMPW-1:0]          conv_data_b,
    output logic                     dma_req,
    output logic [2*SMPW-1:0]        dma_word,
    output logic [INS_RANKS*SMPW-1:0] ins_data_a,
    output logic [INS_RANKS*SMPW-1:0] ins_data_b,
    output logic                     eoc_flag,
    output logic                     eoic_flag,
    output logic                     ovr_flag,
    output logic                     eoc_irq,
    output logic                     eoic_irq,
    output logic                     cfg_err
);
    typedef struct packed {
        logic                             reg_act;
        logic                             ins_act;
        logic                             ins_pend;
        logic [RLW-1:0]                   reg_rank;
        logic [ILW-1:0]                   ins_rank;
        logic                             got_a;
        logic                             got_b;
        logic [SMPW-1:0]                  hold_a;
        logic [SMPW-1:0]                  hold_b;
        logic                             start;
        logic                             dma_req;
        logic [2*SMPW-1:0]                dma_word;
        logic [INS_RANKS-1:0][SMPW-1:0]   ins_a;
        logic [INS_RANKS-1:0][SMPW-1:0]   ins_b;
        logic                             eoc;
        logic                             eoic;
        logic                             ovr;
        logic                             cfg_err;
    } seq_st_t;

    seq_st_t s_d, s_q;

    logic      reg_fire, ins_fire;
    logic      reg_bad, ins_bad;
    logic      busy, both_d, last_reg_d, reg_go_d;
    logic      eoc_set_d, eoic_set_d, ovr_set_d;
    logic [SMPW-1:0] smp_a_d, smp_b_d;
    dcs_grp_e  cur_grp;

    dcs_trig_mux #(.NSRC(NSRC), .SELW(SELW)) u_reg_trig (
        .clk(clk), .rst(rst), .src(reg_trig_src), .sel(reg_sel), .fire(reg_fire)
    );

    dcs_trig_mux #(.NSRC(NSRC), .SELW(SELW)) u_ins_trig (
        .clk(clk), .rst(rst), .src(ins_trig_src), .sel(ins_sel), .fire(ins_fire)
    );

    dcs_cfg_check #(.RANKS(REG_RANKS), .CHW(CHW), .STW(STW), .LW(RLW)) u_reg_chk (
        .ch_a(reg_ch_a), .ch_b(reg_ch_b), .st_a(reg_st_a), .st_b(reg_st_b),
        .len(reg_len), .bad(reg_bad)
    );

    dcs_cfg_check #(.RANKS(INS_RANKS), .CHW(CHW), .STW(STW), .LW(ILW)) u_ins_chk (
        .ch_a(ins_ch_a), .ch_b(ins_ch_b), .st_a(ins_st_a), .st_b(ins_st_b),
        .len(ins_len), .bad(ins_bad)
    );

    always_comb begin
        s_d         = s_q;
        s_d.start   = 1'b0;
        s_d.dma_req = 1'b0;
        s_d.cfg_err = reg_bad | ins_bad;
        eoc_set_d   = 1'b0;
        eoic_set_d  = 1'b0;
        ovr_set_d   = 1'b0;
        reg_go_d    = 1'b0;
        last_reg_d  = 1'b0;
        busy        = s_q.reg_act | s_q.ins_act;
        cur_grp     = s_q.ins_act ? GRP_INS : GRP_REG;
        smp_a_d     = s_q.got_a ? s_q.hold_a : conv_data_a;
        smp_b_d     = s_q.got_b ? s_q.hold_b : conv_data_b;
        both_d      = busy && !s_q.start &&
                      (s_q.got_a || conv_done_a) && (s_q.got_b || conv_done_b);

        if (busy && !s_q.start) begin
            if (conv_done_a && !s_q.got_a) begin
                s_d.got_a  = 1'b1;
                s_d.hold_a = conv_data_a;
            end
            if (conv_done_b && !s_q.got_b) begin
                s_d.got_b  = 1'b1;
                s_d.hold_b = conv_data_b;
            end
        end

        if (both_d) begin
            s_d.got_a = 1'b0;
            s_d.got_b = 1'b0;
            if (cur_grp == GRP_INS) begin
                s_d.ins_a[s_q.ins_rank] = smp_a_d;
                s_d.ins_b[s_q.ins_rank] = smp_b_d;
                if (s_q.ins_rank == ins_len) begin
                    s_d.ins_act  = 1'b0;
                    s_d.ins_rank = '0;
                    eoic_set_d   = 1'b1;
                    s_d.start    = s_q.reg_act;
                end else begin
                    s_d.ins_rank = s_q.ins_rank + 1'b1;
                    s_d.start    = 1'b1;
                end
            end else begin
                s_d.dma_req  = 1'b1;
                s_d.dma_word = {smp_b_d, smp_a_d};
                last_reg_d   = (s_q.reg_rank == reg_len);
                if (last_reg_d) begin
                    s_d.reg_act  = 1'b0;
                    s_d.reg_rank = '0;
                    eoc_set_d    = 1'b1;
                end else begin
                    s_d.reg_rank = s_q.reg_rank + 1'b1;
                end
                if (s_q.ins_pend) begin
                    s_d.ins_pend = 1'b0;
                    s_d.ins_act  = 1'b1;
                    s_d.ins_rank = '0;
                    s_d.start    = 1'b1;
                end else begin
                    s_d.start = !last_reg_d;
                end
            end
        end else if (!busy && s_q.ins_pend) begin
            s_d.ins_pend = 1'b0;
            s_d.ins_act  = 1'b1;
            s_d.ins_rank = '0;
            s_d.start    = 1'b1;
        end

        if (reg_fire && !s_q.cfg_err) begin
            if (busy || s_q.ins_pend) begin
                ovr_set_d = 1'b1;
            end else begin
                reg_go_d     = 1'b1;
                s_d.reg_act  = 1'b1;
                s_d.reg_rank = '0;
                s_d.start    = 1'b1;
            end
        end

        if (ins_fire && !s_q.cfg_err) begin
            if (s_q.ins_act || s_q.ins_pend) begin
                ovr_set_d = 1'b1;
            end else if (s_q.reg_act || reg_go_d) begin
                s_d.ins_pend = 1'b1;
            end else begin
                s_d.ins_act  = 1'b1;
                s_d.ins_rank = '0;
                s_d.start    = 1'b1;
            end
        end

        s_d.eoc  = (s_q.eoc  & ~clr_eoc)  | eoc_set_d;
        s_d.eoic = (s_q.eoic & ~clr_eoic) | eoic_set_d;
        s_d.ovr  = (s_q.ovr  & ~clr_ovr)  | ovr_set_d;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    always_comb begin
        conv_start_a = s_q.start;
        conv_start_b = s_q.start;
        if (s_q.ins_act) begin
            conv_ch_a = ins_ch_a[int'(s_q.ins_rank)*CHW +: CHW];
            conv_ch_b = ins_ch_b[int'(s_q.ins_rank)*CHW +: CHW];
            conv_st_a = ins_st_a[int'(s_q.ins_rank)*STW +: STW];
            conv_st_b = ins_st_b[int'(s_q.ins_rank)*STW +: STW];
        end else begin
            conv_ch_a = reg_ch_a[int'(s_q.reg_rank)*CHW +: CHW];
            conv_ch_b = reg_ch_b[int'(s_q.reg_rank)*CHW +: CHW];
            conv_st_a = reg_st_a[int'(s_q.reg_rank)*STW +: STW];
            conv_st_b = reg_st_b[int'(s_q.reg_rank)*STW +: STW];
        end
        dma_req    = s_q.dma_req;
        dma_word   = s_q.dma_word;
        ins_data_a = s_q.ins_a;
        ins_data_b = s_q.ins_b;
        eoc_flag   = s_q.eoc;
        eoic_flag  = s_q.eoic;
        ovr_flag   = s_q.ovr;
        eoc_irq    = s_q.eoc  & (eoc_ie_a  | eoc_ie_b);
        eoic_irq   = s_q.eoic & (eoic_ie_a | eoic_ie_b);
        cfg_err    = s_q.cfg_err;
    end

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
        conv_start_a |=> !conv_start_a); // R3
    AST_DMA_SINGLE: assert property (@(posedge clk) disable iff (rst)
        dma_req |=> !dma_req); // R4
    AST_EOC_WITH_LAST_DMA: assert property (@(posedge clk) disable iff (rst)
        $rose(eoc_flag) |-> dma_req); // R5
    AST_EOIC_NO_DMA: assert property (@(posedge clk) disable iff (rst)
        $rose(eoic_flag) |-> !dma_req); // R6
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovr_flag && !clr_ovr) |=> ovr_flag); // R8
    AST_EOC_STICKY: assert property (@(posedge clk) disable iff (rst)
        (eoc_flag && !clr_eoc) |=> eoc_flag); // R9
    AST_CFG_BLOCKS_START: assert property (@(posedge clk) disable iff (rst)
        (cfg_err && !busy && !s_q.ins_pend) |=> !conv_start_a); // R10
endmodule

// File: tb/dual_conv_seq_tb_top.sv
module dual_conv_seq_tb_top;
    localparam int DW = 16, RR = 16, IR = 4, CHW = 5, STW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [7:0] reg_trig_src = '0, ins_trig_src = '0;
    logic [2:0] reg_sel = 3'd5, ins_sel = 3'd1;
    logic [3:0] reg_len = '0;
    logic [1:0] ins_len = '0;
    logic [RR*CHW-1:0] reg_ch_a, reg_ch_b;
    logic [RR*STW-1:0] reg_st_a, reg_st_b;
    logic [IR*CHW-1:0] ins_ch_a, ins_ch_b;
    logic [IR*STW-1:0] ins_st_a, ins_st_b;
    logic eoc_ie_a = 0, eoc_ie_b = 0, eoic_ie_a = 0, eoic_ie_b = 0;
    logic clr_eoc = 0, clr_eoic = 0, clr_ovr = 0;
    logic conv_start_a, conv_start_b;
    logic [CHW-1:0] conv_ch_a, conv_ch_b;
    logic [STW-1:0] conv_st_a, conv_st_b;
    logic conv_done_a = 0, conv_done_b = 0;
    logic [DW-1:0] conv_data_a = '0, conv_data_b = '0;
    logic dma_req;
    logic [2*DW-1:0] dma_word;
    logic [IR*DW-1:0] ins_data_a, ins_data_b;
    logic eoc_flag, eoic_flag, ovr_flag, eoc_irq, eoic_irq, cfg_err;

    dual_conv_seq dut_i (
        .clk(clk), .rst(rst), .reg_trig_src(reg_trig_src), .ins_trig_src(ins_trig_src),
        .reg_sel(reg_sel), .ins_sel(ins_sel), .reg_len(reg_len), .ins_len(ins_len),
        .reg_ch_a(reg_ch_a), .reg_ch_b(reg_ch_b), .reg_st_a(reg_st_a), .reg_st_b(reg_st_b),
        .ins_ch_a(ins_ch_a), .ins_ch_b(ins_ch_b), .ins_st_a(ins_st_a), .ins_st_b(ins_st_b),
        .eoc_ie_a(eoc_ie_a), .eoc_ie_b(eoc_ie_b), .eoic_ie_a(eoic_ie_a), .eoic_ie_b(eoic_ie_b),
        .clr_eoc(clr_eoc), .clr_eoic(clr_eoic), .clr_ovr(clr_ovr),
        .conv_start_a(conv_start_a), .conv_start_b(conv_start_b),
        .conv_ch_a(conv_ch_a), .conv_ch_b(conv_ch_b), .conv_st_a(conv_st_a), .conv_st_b(conv_st_b),
        .conv_done_a(conv_done_a), .conv_done_b(conv_done_b),
        .conv_data_a(conv_data_a), .conv_data_b(conv_data_b),
        .dma_req(dma_req), .dma_word(dma_word), .ins_data_a(ins_data_a), .ins_data_b(ins_data_b),
        .eoc_flag(eoc_flag), .eoic_flag(eoic_flag), .ovr_flag(ovr_flag),
        .eoc_irq(eoc_irq), .eoic_irq(eoic_irq), .cfg_err(cfg_err)
    );

    int nchk = 0, nerr = 0;
    int lat_a = 3, lat_b = 5;
    int cd_a = 0, cd_b = 0;
    bit pend_a = 0, pend_b = 0;
    logic [CHW-1:0] lch_a, lch_b;
    int ns = 0, nw = 0, mism = 0;
    logic [CHW-1:0] slog_a [64];
    logic [CHW-1:0] slog_b [64];
    logic [STW-1:0] stlog_a [64];
    logic [STW-1:0] stlog_b [64];
    logic [2*DW-1:0] words [64];
    logic eocw [64];

    function automatic logic [DW-1:0] fa(input logic [CHW-1:0] ch);
        return 16'hA000 | 16'(ch);
    endfunction
    function automatic logic [DW-1:0] fb(input logic [CHW-1:0] ch);
        return 16'hB000 | 16'(ch);
    endfunction

    // converter models and monitors, all at the falling edge
    always @(negedge clk) begin
        conv_done_a = 1'b0;
        conv_done_b = 1'b0;
        if (conv_start_a != conv_start_b) mism++;
        if (conv_start_a) begin
            if (ns < 64) begin
                slog_a[ns] = conv_ch_a; slog_b[ns] = conv_ch_b;
                stlog_a[ns] = conv_st_a; stlog_b[ns] = conv_st_b;
            end
            ns++;
            pend_a = 1; cd_a = lat_a; lch_a = conv_ch_a;
            pend_b = 1; cd_b = lat_b; lch_b = conv_ch_b;
        end else begin
            if (pend_a) begin
                cd_a--;
                if (cd_a == 0) begin pend_a = 0; conv_done_a = 1; conv_data_a = fa(lch_a); end
            end
            if (pend_b) begin
                cd_b--;
                if (cd_b == 0) begin pend_b = 0; conv_done_b = 1; conv_data_b = fb(lch_b); end
            end
        end
        if (dma_req) begin
            if (nw < 64) begin words[nw] = dma_word; eocw[nw] = eoc_flag; end
            nw++;
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        ns = 0; nw = 0; mism = 0;
    endtask

    task automatic set_reg(input int r, input int a, input int b, input int sa, input int sb);
        reg_ch_a[r*CHW +: CHW] = CHW'(a); reg_ch_b[r*CHW +: CHW] = CHW'(b);
        reg_st_a[r*STW +: STW] = STW'(sa); reg_st_b[r*STW +: STW] = STW'(sb);
    endtask

    task automatic set_ins(input int r, input int a, input int b);
        ins_ch_a[r*CHW +: CHW] = CHW'(a); ins_ch_b[r*CHW +: CHW] = CHW'(b);
        ins_st_a[r*STW +: STW] = 3'd4; ins_st_b[r*STW +: STW] = 3'd4;
    endtask

    task automatic pulse_reg(input int idx);
        reg_trig_src[idx] = 1'b1; tick(); reg_trig_src[idx] = 1'b0;
    endtask

    task automatic pulse_ins(input int idx);
        ins_trig_src[idx] = 1'b1; tick(); ins_trig_src[idx] = 1'b0;
    endtask

    task automatic wait_eoc();
        for (int i = 0; i < 3000 && !eoc_flag; i++) tick();
    endtask

    task automatic wait_eoic();
        for (int i = 0; i < 3000 && !eoic_flag; i++) tick();
    endtask

    task automatic clear_all();
        clr_eoc = 1; clr_eoic = 1; clr_ovr = 1; tick();
        clr_eoc = 0; clr_eoic = 0; clr_ovr = 0; tick();
    endtask

    task automatic default_cfg();
        for (int r = 0; r < RR; r++) set_reg(r, r, r + 16, 1, 1);
        for (int r = 0; r < IR; r++) set_ins(r, 8 + r, 12 + r);
    endtask

    task automatic t_reset_state();
        chk(!eoc_flag && !eoic_flag && !ovr_flag, "R1 flags after reset", {eoc_flag, eoic_flag, ovr_flag}, 0);
        chk(!dma_req && !conv_start_a && !conv_start_b, "R1 idle outputs after reset", {dma_req, conv_start_a}, 0);
        chk(!cfg_err && !eoc_irq && !eoic_irq, "R1 cfg/irq after reset", {cfg_err, eoc_irq, eoic_irq}, 0);
    endtask

    task automatic t_wrong_source();
        clear_logs();
        pulse_reg(2); pulse_ins(5); tick(12);
        chk(ns == 0 && nw == 0, "R2 unselected lines ignored", ns, 0);
    endtask

    task automatic t_regular8();
        reg_len = 4'd7; lat_a = 7; lat_b = 2;
        for (int r = 0; r < 8; r++) set_reg(r, r, (r + 14) % 16, 2, 2);
        eoc_ie_a = 0; eoc_ie_b = 1;
        tick(2); clear_logs();
        pulse_reg(5);
        wait_eoc(); tick(3);
        chk(ns == 8, "R3 start count regular", ns, 8);
        chk(mism == 0, "R3 starts paired", mism, 0);
        chk(slog_a[3] == 5'd3 && slog_b[3] == 5'd1, "R3 per-side channel rank3", {slog_a[3], slog_b[3]}, {5'd3, 5'd1});
        chk(stlog_a[5] == 3'd2 && stlog_b[5] == 3'd2, "R3 sample time rank5", {stlog_a[5], stlog_b[5]}, {3'd2, 3'd2});
        chk(nw == 8, "R4 one DMA per rank", nw, 8);
        for (int r = 0; r < 8; r++) begin
            logic [31:0] e;
            e = {fb(CHW'((r + 14) % 16)), fa(CHW'(r))};
            chk(words[r] == e, "R4 packed word", words[r], e);
        end
        chk(eocw[6] == 0 && eocw[7] == 1, "R5 eoc with last rank only", {eocw[6], eocw[7]}, 2'b01);
        chk(eoc_irq == 1, "R5 irq enabled by side B", eoc_irq, 1);
        eoc_ie_b = 0; tick();
        chk(eoc_irq == 0 && eoc_flag == 1, "R5 irq gated off", {eoc_irq, eoc_flag}, 2'b01);
        tick(20);
        chk(eoc_flag == 1, "R9 eoc sticky", eoc_flag, 1);
        clr_eoc = 1; tick(); clr_eoc = 0;
        chk(eoc_flag == 0, "R9 eoc cleared by pulse", eoc_flag, 0);
    endtask

    task automatic t_full16();
        reg_len = 4'd15; lat_a = 2; lat_b = 6;
        for (int r = 0; r < RR; r++) set_reg(r, r, (r + 14) % 16, 3, 3);
        tick(2); clear_logs();
        pulse_reg(5);
        wait_eoc(); tick(3);
        chk(nw == 16, "R5 full 16-rank scan", nw, 16);
        chk(words[15] == {fb(5'd13), fa(5'd15)}, "R4 last packed word", words[15], {fb(5'd13), fa(5'd15)});
        chk(eocw[14] == 0 && eocw[15] == 1, "R5 eoc at rank 15", {eocw[14], eocw[15]}, 2'b01);
        clear_all();
    endtask

    task automatic t_inserted();
        ins_len = 2'd3; lat_a = 4; lat_b = 3;
        for (int r = 0; r < IR; r++) set_ins(r, 8 + r, 12 + r);
        eoic_ie_a = 1; eoic_ie_b = 0;
        tick(2); clear_logs();
        pulse_ins(1);
        wait_eoic(); tick(3);
        chk(ns == 4 && nw == 0, "R6 four ranks, no DMA", {ns, nw}, {32'd4, 32'd0});
        for (int r = 0; r < IR; r++) begin
            chk(ins_data_a[r*DW +: DW] == fa(CHW'(8 + r)), "R6 side A result", ins_data_a[r*DW +: DW], fa(CHW'(8 + r)));
            chk(ins_data_b[r*DW +: DW] == fb(CHW'(12 + r)), "R6 side B result", ins_data_b[r*DW +: DW], fb(CHW'(12 + r)));
        end
        chk(eoic_irq == 1, "R6 eoic irq", eoic_irq, 1);
        clr_eoic = 1; tick(); clr_eoic = 0;
        chk(eoic_flag == 0, "R9 eoic cleared", eoic_flag, 0);
    endtask

    task automatic t_preempt();
        reg_len = 4'd5; ins_len = 2'd3; lat_a = 3; lat_b = 5;
        for (int r = 0; r < 6; r++) set_reg(r, r, 20 + r, 1, 1);
        for (int r = 0; r < IR; r++) set_ins(r, 8 + r, 12 + r);
        tick(2); clear_all(); clear_logs();
        pulse_reg(5);
        for (int i = 0; i < 500 && nw < 2; i++) tick();
        tick(2);
        pulse_ins(1);
        wait_eoc(); wait_eoic(); tick(3);
        begin
            int ea [10] = '{0, 1, 2, 8, 9, 10, 11, 3, 4, 5};
            int eb [10] = '{20, 21, 22, 12, 13, 14, 15, 23, 24, 25};
            bit ok = (ns == 10);
            for (int k = 0; k < 10; k++)
                if (slog_a[k] != CHW'(ea[k]) || slog_b[k] != CHW'(eb[k])) ok = 0;
            chk(ok, "R7 pause, inserted group, resume order", ns, 10);
        end
        chk(nw == 6 && words[3] == {fb(5'd23), fa(5'd3)}, "R7 resumed rank word", words[3], {fb(5'd23), fa(5'd3)});
        chk(eoc_flag && eoic_flag && !ovr_flag, "R7 both groups ended", {eoc_flag, eoic_flag, ovr_flag}, 3'b110);
        clear_all();
    endtask

    task automatic t_overrun();
        reg_len = 4'd3; lat_a = 4; lat_b = 4;
        for (int r = 0; r < 4; r++) set_reg(r, r, 20 + r, 1, 1);
        tick(2); clear_logs();
        pulse_reg(5); tick(3);
        pulse_reg(5);
        tick();
        chk(ovr_flag == 1, "R8 regular retrigger overrun", ovr_flag, 1);
        wait_eoc(); tick(3);
        chk(nw == 4, "R8 retrigger ignored", nw, 4);
        tick(10);
        chk(ovr_flag == 1, "R9 ovr sticky", ovr_flag, 1);
        clear_all();
        chk(ovr_flag == 0, "R9 ovr cleared", ovr_flag, 0);
        clear_logs();
        pulse_ins(1); tick(2); pulse_ins(1); tick();
        chk(ovr_flag == 1, "R8 inserted retrigger overrun", ovr_flag, 1);
        wait_eoic(); tick(3);
        chk(ns == 4, "R8 inserted run not restarted", ns, 4);
        clear_all();
    endtask

    task automatic t_cfg();
        reg_len = 4'd3;
        for (int r = 0; r < RR; r++) set_reg(r, r, r + 16, 1, 1);
        set_reg(0, 7, 7, 1, 1);
        tick(2);
        chk(cfg_err == 1, "R10 same channel on rank0", cfg_err, 1);
        clear_logs();
        pulse_reg(5); pulse_ins(1); tick(10);
        chk(ns == 0 && ovr_flag == 0, "R10 triggers refused while error", {ns, 31'd0, ovr_flag}, 0);
        set_reg(0, 0, 16, 1, 1); set_reg(2, 2, 18, 1, 5);
        tick(2);
        chk(cfg_err == 1, "R10 sample time mismatch", cfg_err, 1);
        set_reg(2, 2, 18, 1, 1); set_reg(6, 6, 6, 2, 7);
        tick(2);
        chk(cfg_err == 0, "R10 rank above length unchecked", cfg_err, 0);
        set_reg(6, 6, 22, 1, 1);
        tick(2);
    endtask

    task automatic t_mid_reset();
        reg_len = 4'd5; lat_a = 3; lat_b = 3;
        tick(2); clear_all();
        pulse_reg(5); tick(8);
        rst = 1; tick(2); rst = 0; tick();
        chk(!eoc_flag && !dma_req && !conv_start_a, "R1 reset mid-scan", {eoc_flag, dma_req}, 0);
        tick(10); clear_logs();
        pulse_reg(5); tick(2);
        chk(ns == 1 && slog_a[0] == 5'd0, "R1 scan restarts at rank0", {ns, 27'd0, slog_a[0]}, {32'd1, 32'd0});
        wait_eoc(); tick(3);
        clear_all();
    endtask

    initial begin
        default_cfg();
        tick(3);
        rst = 0;
        tick(2);
        t_reset_state();
        t_wrong_source();
        t_regular8();
        t_full16();
        t_inserted();
        t_preempt();
        t_overrun();
        t_cfg();
        t_mid_reset();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule